// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block decides when a new task may enter a statically configured nonlinear pipeline. Stage usage of one task is described by a reservation table: one row per stage, one column per clock cycle of the task's evaluation time, with a mark where the task occupies that stage. On a configuration strobe the controller reduces the table to a collision vector: the set of initiation spacings that would put two tasks in one stage during the same cycle.

At run time a requester raises a request and holds it. The controller grants it in the same cycle when starting now clashes with no task still in flight. Otherwise it flags the request as waiting until the spacing becomes legal. The controller tracks the schedule in a shift register that is only as wide as the largest spacing that can be forbidden. It also reports the spacing between the two most recent grants and keeps a running count of grants.

Top module: `pipe_init_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the schedule, the collision vector, `grant_count` and `latency`. A request raised in the first cycle after reset is granted in that cycle.
- R2: While `cfg_load` is high, the controller captures a collision vector from `cfg_table` and clears the schedule, and no grant is given in that cycle. Table bit `s*COLS + c` marks stage `s` busy at column `c`. Spacing L (1..COLS-1) is forbidden when some row has marks at columns c and c+L.
- R3: `grant` is combinational. It is 1 in the same cycle as `req` when `cfg_load` is low and the current cycle is a permitted spacing from every earlier grant.
- R4: A request that comes L cycles after any earlier grant, with L forbidden, is not granted in that cycle.
- R5: Spacings of COLS or more are always permitted, so a request COLS cycles after the last grant is granted regardless of the table.
- R6: `busy` is 1 exactly when `req` is high and not granted in that cycle. A request held high is granted at the first permitted cycle.
- R7: In the cycle after a grant, `latency` holds the number of cycles since the previous grant, saturating at 2^LAT_W-1. The first grant after reset reports that saturated value.
- R8: `grant_count` rises by one after each grant (wrapping at 2^CNT_W) and is unchanged otherwise.
- R9: A diagonal table (stage s used only at column s) forbids no spacing, so a request held high is granted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture reservation table and clear schedule |
| cfg_table | input | STAGES*COLS | Reservation table, bit s*COLS+c = stage s busy at column c |
| req | input | 1 | Initiation request, held until granted |
| grant | output | 1 | Initiation accepted this cycle |
| busy | output | 1 | Request waiting this cycle |
| latency | output | LAT_W | Cycles between the two latest grants |
| grant_count | output | CNT_W | Number of grants, wrapping |

## Verification
The bench uses the defaults: four stages, eight columns, an 8-bit latency field and a 16-bit counter. With eight columns, the widest forbidden spacing (7) and the first always-free spacing (8) can both be reached within a few cycles. An 8-bit latency field lets a 300-cycle idle gap exercise saturation. Random four-by-eight tables are mixed with directed full-row, diagonal and end-column tables. Together they cover empty, full and sparse collision vectors, and a per-grant history model in the bench predicts each decision.

// File: rtl/pipe_init_ctrl.sv
module pipe_init_ctrl #(
  parameter int STAGES = 4,
  parameter int COLS   = 8,
  parameter int LAT_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_load,
  input  logic [STAGES*COLS-1:0]  cfg_table,
  input  logic                    req,
  output logic                    grant,
  output logic                    busy,
  output logic [LAT_W-1:0]        latency,
  output logic [CNT_W-1:0]        grant_count
);
  localparam int MAXLAT = COLS - 1;
  localparam logic [LAT_W-1:0] LAT_SAT = {LAT_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  logic [MAXLAT-1:0] cv_new, cvec, sched;
  logic [LAT_W-1:0]  since;

  always_comb begin
    cv_new = '0;
    for (int s = 0; s < STAGES; s++)
      for (int a = 0; a < COLS; a++)
        for (int b = a + 1; b < COLS; b++)
          if (cfg_table[s*COLS + a] && cfg_table[s*COLS + b])
            cv_new[b-a-1] = 1'b1;
  end

  assign grant = req & ~cfg_load & ~sched[0];
  assign busy  = req & ~grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      cvec        <= '0;
      sched       <= '0;
      since       <= LAT_SAT;
      latency     <= '0;
      grant_count <= '0;
    end else begin
      if (cfg_load) begin
        cvec  <= cv_new;
        sched <= '0;
      end else begin
        sched <= (sched >> 1) | (grant ? cvec : '0);
      end
      if (grant) begin
        since       <= LAT_ONE;
        latency     <= since;
        grant_count <= grant_count + 1'b1;
      end else if (since != LAT_SAT) begin
        since <= since + 1'b1;
      end
    end
  end
endmodule

module pipe_init_ctrl_chk #(
  parameter int LAT_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic             req,
  input logic             grant,
  input logic             cv0,
  input logic [LAT_W-1:0] latency,
  input logic [CNT_W-1:0] grant_count
);
  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    grant |=> grant_count == CNT_W'($past(grant_count) + 1'b1));
  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !grant |=> $stable(grant_count));
  // R3
  grant_req_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> req);
  // R2
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> !grant);
  // R4
  lat_one_chk: assert property (@(posedge clk) disable iff (rst)
    grant && cv0 |=> !grant);
  // R7
  lat_nz_chk: assert property (@(posedge clk) disable iff (rst)
    grant |=> latency != '0);
  // R1
  first_req_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && req && !cfg_load |-> grant);
endmodule

bind pipe_init_ctrl pipe_init_ctrl_chk #(.LAT_W(LAT_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .req(req), .grant(grant),
  .cv0(cvec[0]), .latency(latency), .grant_count(grant_count)
);

// File: tb/pipe_init_ctrl_test.sv
module pipe_init_ctrl_test;
  localparam int STAGES = 4;
  localparam int COLS   = 8;
  localparam int LAT_W  = 8;
  localparam int CNT_W  = 16;
  localparam int TW     = STAGES*COLS;

  logic clk = 0, rst = 1, cfg_load = 0, req = 0;
  logic [TW-1:0] cfg_table = '0;
  logic grant, busy;
  logic [LAT_W-1:0] latency;
  logic [CNT_W-1:0] grant_count;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [COLS-1:0] m_cv;
  bit m_hist [1:COLS];
  int m_since, m_lat, m_cnt;

  pipe_init_ctrl #(.STAGES(STAGES), .COLS(COLS), .LAT_W(LAT_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_table(cfg_table), .req(req),
    .grant(grant), .busy(busy), .latency(latency), .grant_count(grant_count));

  always #2.5 clk = ~clk;

  function automatic logic [COLS-1:0] calc_cv(input logic [TW-1:0] t);
    logic [COLS-1:0] v = '0;
    for (int s = 0; s < STAGES; s++)
      for (int a = 0; a < COLS; a++)
        for (int l = 1; a + l < COLS; l++)
          if (t[s*COLS+a] && t[s*COLS+a+l]) v[l] = 1'b1;
    return v;
  endfunction

  function automatic bit blocked();
    for (int k = 1; k < COLS; k++)
      if (m_hist[k] && m_cv[k]) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cv = '0;
    for (int k = 1; k <= COLS; k++) m_hist[k] = 0;
    m_since = (1 << LAT_W) - 1;
    m_lat = 0;
    m_cnt = 0;
  endtask

  task automatic step(input bit c, input logic [TW-1:0] t, input bit r, input string tag);
    bit eg;
    cfg_load = c; cfg_table = t; req = r;
    #1;
    eg = r && !c && !blocked();
    chk(tag, "grant", grant, eg);
    chk("R6", "busy", busy, r && !eg);
    @(posedge clk);
    if (c) begin
      m_cv = calc_cv(t);
      for (int k = 1; k <= COLS; k++) m_hist[k] = 0;
    end else begin
      for (int k = COLS; k >= 2; k--) m_hist[k] = m_hist[k-1];
      m_hist[1] = eg;
    end
    if (eg) begin
      m_lat = m_since;
      m_since = 1;
      m_cnt = (m_cnt + 1) % (1 << CNT_W);
    end else if (m_since < (1 << LAT_W) - 1) m_since++;
    @(negedge clk);
    chk("R7", "latency", latency, m_lat);
    chk("R8", "grant_count", grant_count, m_cnt);
  endtask

  task automatic load(input logic [TW-1:0] t);
    step(1, t, 0, "R2");
  endtask

  initial begin : wd
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [TW-1:0] t;
    bit r;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "grant_count after reset", grant_count, 0);
    chk("R1", "latency after reset", latency, 0);
    step(0, '0, 1, "R1");

    t = '0; t[0] = 1; t[COLS-1] = 1;
    load(t);
    for (int i = 0; i < 10; i++) step(0, '0, 1, "R4");
    step(0, '0, 0, "R5");
    load(t);
    step(0, '0, 1, "R3");
    for (int i = 0; i < COLS - 1; i++) step(0, '0, 0, "R5");
    step(0, '0, 1, "R5");

    t = '0;
    for (int s = 0; s < STAGES; s++) t[s*COLS + s] = 1;
    load(t);
    for (int i = 0; i < 12; i++) step(0, '0, 1, "R9");

    t = '0; t[COLS-1:0] = '1;
    load(t);
    for (int i = 0; i < 3*COLS; i++) step(0, '0, 1, "R4");

    step(1, t, 1, "R2");
    for (int i = 0; i < 300; i++) step(0, '0, 0, "R7");
    step(0, '0, 1, "R7");

    for (int n = 0; n < 40; n++) begin
      t = '0;
      for (int b = 0; b < TW; b++) t[b] = ($urandom % 4) == 0;
      load(t);
      for (int i = 0; i < 60; i++) begin
        r = busy ? 1'b1 : (($urandom % 3) != 0);
        step(0, '0, r, "R4");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule